// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous request stream and an external asynchronous static RAM built from four 8-bit byte lanes. The lanes share one 19-bit address bus and one active-low output enable. Each lane has its own active-low chip select and its own active-low write enable. A requester hands over one access at a time: an address, write data, a write flag and a width mode. The controller then sequences the memory strobes. Every phase length is a whole number of clock cycles, derived from nanosecond timing parameters by rounding up against a clock-period parameter.

The width mode lets the one 32-bit-wide memory serve as a 32-bit, 16-bit or 8-bit deep memory. In the narrow modes the low bits of the user address pick the lanes and the remaining bits form the memory address. Narrow write data comes from the low bits of the write bus, and narrow read data comes back right-aligned with zeros above it. Reads finish with a one-cycle response pulse. Writes are ended by the write enable, and chip select stays low across the whole write pulse.

Request handshake: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. A requester facing low ready keeps `req_valid` and its fields steady until the transfer. Request inputs seen while the controller is busy have no effect on the access in flight. `rsp_valid` carries no back-pressure: the requester must take the data in the cycle it is shown.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever idle, `req_ready`=1, every bit of `sram_cs_n` and `sram_we_n` is 1, `sram_oe_n`=1, `sram_dq_oe`=0 and `rsp_valid`=0.
- R2: Mode 2'b00 (32-bit) selects all four lanes. `sram_addr` = `req_addr[18:0]`, and lane n (data bits 8n+7..8n, lane 0 lowest) carries `req_wdata[8n+7:8n]`.
- R3: Mode 2'b01 (16-bit) sets `sram_addr` = `req_addr[19:1]`. When `req_addr[0]`=0 it selects lanes 0-1; when `req_addr[0]`=1 it selects lanes 2-3. The lower selected lane carries `req_wdata[7:0]` and the upper one carries `req_wdata[15:8]`.
- R4: Mode 2'b10 (8-bit) sets `sram_addr` = `req_addr[20:2]` and selects the single lane numbered `req_addr[1:0]`. That lane carries `req_wdata[7:0]`.
- R5: A read holds the selected chip selects and `sram_oe_n` low, with every write enable high, for exactly RD cycles. RD = max(1, ceil(tRC/Tclk), ceil(tAA/Tclk), ceil(tACS/Tclk)). The first of these cycles follows the accepting edge.
- R6: The read response is one cycle of `rsp_valid` in the cycle after the last access cycle. Its data is the memory value present in that last cycle. In 16-bit and 8-bit modes the selected lanes are packed into the low bits and every other bit is 0.
- R7: A write takes three phases in turn. First comes one setup cycle with chip selects low and write enables high. Next come WP cycles with the selected chip selects and write enables low, where WP = max(1, ceil(tWP/Tclk), ceil(tDW/Tclk), ceil(tCW/Tclk)-1). Last come REC cycles with all strobes high and `req_ready`=0, where REC = max(1, ceil(tWC/Tclk)-WP-1).
- R8: `sram_dq_oe` is 1 only in cycles where some write enable is low and `sram_oe_n` is 1. During those cycles the selected lanes of `sram_dq_o` hold the write data.
- R9: The cycle after a read's last access cycle has every strobe high and `req_ready`=0, so a write can never follow a read without an idle bus cycle.
- R10: A request transfers only on an edge where `req_valid` and `req_ready` are both high. While busy, changes on the request inputs leave `sram_addr`, the strobes and the response unchanged.
- R11: Unselected lanes keep their chip select and write enable high for the whole access. A write enable is never low on a lane whose chip select is high.
- R12: Mode 2'b11 behaves exactly like mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Width mode: 00 32-bit, 01 16-bit, 10 8-bit, 11 32-bit |
| req_addr | input | 21 | User address in units of the selected width |
| req_wdata | input | 32 | Write data, narrow modes use the low bits |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 32 | Read data, right-aligned in narrow modes |
| sram_addr | output | 19 | Memory address shared by all lanes |
| sram_cs_n | output | 4 | Per-lane chip select, active low |
| sram_we_n | output | 4 | Per-lane write enable, active low |
| sram_oe_n | output | 1 | Shared output enable, active low |
| sram_dq_o | output | 32 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 32 | Data from the memory |

## Verification
In the same cycle a read response can be on `rsp_valid` while the next request is already waiting on the request inputs. The bench provokes this by keeping `req_valid` high from one request straight into the next, so a write is waiting while a read is still finishing. The cycle-accurate reference model is checked on every clock, and it judges that cycle by requiring the correct response data, all strobes high and `req_ready` low at once. The waiting write's setup cycle must begin only after the following idle cycle. Random mixes of widths, lanes and directions over a small address range also set narrow writes against wide reads of the same word, which checks lane placement.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    WM_32    = 2'b00,
    WM_16    = 2'b01,
    WM_8     = 2'b10,
    WM_32ALT = 2'b11
  } width_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_TURN   = 3'd2,
    ST_WSETUP = 3'd3,
    ST_WPULSE = 3'd4,
    ST_WREC   = 3'd5
  } seq_state_e;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int SEL_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W,
  localparam int UA_W   = ADDR_W + SEL_W
) (
  input  width_mode_e       mode,
  input  logic [UA_W-1:0]   uaddr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [LANES-1:0]  lane_mask,
  output logic [DATA_W-1:0] lane_wdata,
  output logic [SEL_W-1:0]  sub_sel
);
  localparam int PSEL_W = SEL_W - 1;

  logic              is16, is8;
  logic [PSEL_W-1:0] pair_idx;
  logic [SEL_W-1:0]  lane_idx;

  assign is16     = (mode == WM_16);
  assign is8      = (mode == WM_8);
  assign pair_idx = uaddr[PSEL_W-1:0];
  assign lane_idx = uaddr[SEL_W-1:0];

  always_comb begin
    if (is8)       phys_addr = uaddr[SEL_W +: ADDR_W];
    else if (is16) phys_addr = uaddr[PSEL_W +: ADDR_W];
    else           phys_addr = uaddr[ADDR_W-1:0];
  end

  assign sub_sel = is16 ? SEL_W'(pair_idx) : lane_idx;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [PSEL_W-1:0] MY_PAIR = PSEL_W'(l / 2);
    localparam logic [SEL_W-1:0]  MY_LANE = SEL_W'(l);
    assign lane_mask[l] = is8  ? (lane_idx == MY_LANE) :
                          is16 ? (pair_idx == MY_PAIR) : 1'b1;
    assign lane_wdata[l*LANE_W +: LANE_W] =
      is8  ? wdata[LANE_W-1:0] :
      is16 ? wdata[(l%2)*LANE_W +: LANE_W] :
             wdata[l*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/sram_read_align.sv
module sram_read_align
  import sram_ctrl_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int SEL_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  width_mode_e       mode,
  input  logic [SEL_W-1:0]  sub_sel,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int HALF_W = 2 * LANE_W;
  localparam int PSEL_W = SEL_W - 1;

  logic [DATA_W-1:0] aligned;

  always_comb begin
    aligned = '0;
    case (mode)
      WM_16:   aligned[HALF_W-1:0] = dq_i[int'(sub_sel[PSEL_W-1:0]) * HALF_W +: HALF_W];
      WM_8:    aligned[LANE_W-1:0] = dq_i[int'(sub_sel) * LANE_W +: LANE_W];
      default: aligned = dq_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= cap_en;
      if (cap_en) rdata <= aligned;
    end
  end

  // R6
  rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 2,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 1,
  localparam int CNT_W  = $clog2(imax(imax(RD_CYC, WP_CYC), REC_CYC) + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic act_q,
  output logic oe_q,
  output logic we_q,
  output logic cap_en
);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  seq_state_e       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign cap_en    = (state == ST_READ) && (cnt == '0);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    case (state)
      ST_IDLE: if (req_valid) begin
        state_n = req_write ? ST_WSETUP : ST_READ;
        cnt_n   = RD_LD;
      end
      ST_READ:
        if (cnt == '0) state_n = ST_TURN;
        else           cnt_n   = cnt - ONE;
      ST_TURN: state_n = ST_IDLE;
      ST_WSETUP: begin
        state_n = ST_WPULSE;
        cnt_n   = WP_LD;
      end
      ST_WPULSE:
        if (cnt == '0) begin
          state_n = ST_WREC;
          cnt_n   = REC_LD;
        end else cnt_n = cnt - ONE;
      ST_WREC:
        if (cnt == '0) state_n = ST_IDLE;
        else           cnt_n   = cnt - ONE;
      default: state_n = ST_IDLE;
    endcase
  end

  // strobe flags are flops so the memory pins never see decode glitches
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      act_q <= 1'b0;
      oe_q  <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      act_q <= (state_n == ST_READ) || (state_n == ST_WSETUP) || (state_n == ST_WPULSE);
      oe_q  <= (state_n == ST_READ);
      we_q  <= (state_n == ST_WPULSE);
    end
  end

  // R9
  turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ && cnt == '0) |=> (!act_q && !oe_q && !req_ready));

  // R8
  we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    we_q |-> (act_q && !oe_q));

  // R7
  wsetup_first_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write) |=> (act_q && !we_q && !oe_q));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter int CLK_NS   = 8,
  parameter int T_RC_NS  = 12,
  parameter int T_AA_NS  = 12,
  parameter int T_ACS_NS = 12,
  parameter int T_WC_NS  = 12,
  parameter int T_WP_NS  = 10,
  parameter int T_DW_NS  = 8,
  parameter int T_CW_NS  = 10,
  localparam int SEL_W   = $clog2(LANES),
  localparam int DATA_W  = LANES * LANE_W,
  localparam int UA_W    = ADDR_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  input  logic [UA_W-1:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [LANES-1:0]  sram_cs_n,
  output logic [LANES-1:0]  sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int RD_CYC = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                               ns_to_cyc(T_ACS_NS, CLK_NS));
  localparam int WP_CYC = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                               ns_to_cyc(T_CW_NS, CLK_NS) - 1);
  localparam int REC_CYC = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - WP_CYC - 1);

  width_mode_e       mode_in, mode_q;
  logic [ADDR_W-1:0] map_addr, addr_q;
  logic [LANES-1:0]  map_mask, mask_q;
  logic [DATA_W-1:0] map_wdata, wdata_q;
  logic [SEL_W-1:0]  map_sel, sel_q;
  logic              accept, act_q, oe_q, we_q, cap_en;

  assign mode_in = width_mode_e'(req_mode);

  sram_lane_map #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_map (
    .mode      (mode_in),
    .uaddr     (req_addr),
    .wdata     (req_wdata),
    .phys_addr (map_addr),
    .lane_mask (map_mask),
    .lane_wdata(map_wdata),
    .sub_sel   (map_sel)
  );

  sram_seq #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .act_q    (act_q),
    .oe_q     (oe_q),
    .we_q     (we_q),
    .cap_en   (cap_en)
  );

  // request fields are frozen at the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
      sel_q   <= '0;
      mode_q  <= WM_32;
    end else if (accept) begin
      addr_q  <= map_addr;
      mask_q  <= map_mask;
      wdata_q <= map_wdata;
      sel_q   <= map_sel;
      mode_q  <= mode_in;
    end
  end

  sram_read_align #(.LANES(LANES), .LANE_W(LANE_W)) u_align (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .mode   (mode_q),
    .sub_sel(sel_q),
    .dq_i   (sram_dq_i),
    .rdata  (rsp_rdata),
    .rvalid (rsp_valid)
  );

  assign sram_addr  = addr_q;
  assign sram_cs_n  = ~(mask_q & {LANES{act_q}});
  assign sram_we_n  = ~(mask_q & {LANES{we_q}});
  assign sram_oe_n  = ~oe_q;
  assign sram_dq_o  = wdata_q;
  assign sram_dq_oe = we_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (&sram_cs_n && &sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_valid));

  // R11
  lane_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ((~sram_we_n) & sram_cs_n) == '0);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(sram_addr));

endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  localparam int TCLK = 8;

  function automatic int cdiv(input int t);
    int c;
    c = (t + TCLK - 1) / TCLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // phase lengths from the requirement formulas (12/12/12, 10/8/10, 12 ns)
  localparam int RD  = mx(mx(cdiv(12), cdiv(12)), cdiv(12));
  localparam int WP  = mx(mx(cdiv(10), cdiv(8)), cdiv(10) - 1);
  localparam int REC = mx(1, cdiv(12) - WP - 1);

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_mode;
  logic [20:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [18:0] sram_addr;
  logic [3:0]  sram_cs_n, sram_we_n;
  logic        sram_oe_n, sram_dq_oe;
  logic [31:0] sram_dq_o, sram_dq_i;

  always #(TCLK/2) clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural memory pins: responds to the strobes only
  logic [7:0] ram [int];
  logic [7:0] shadow [int];

  function automatic logic [7:0] ram_rd(input int k);
    return ram.exists(k) ? ram[k] : 8'h00;
  endfunction
  function automatic logic [7:0] sh_rd(input int k);
    return shadow.exists(k) ? shadow[k] : 8'h00;
  endfunction

  always @(*) begin
    for (int l = 0; l < 4; l++)
      sram_dq_i[l*8 +: 8] = (!sram_cs_n[l] && sram_we_n[l] && !sram_oe_n)
                            ? ram_rd(int'(sram_addr) * 4 + l) : 8'hA5;
  end

  always @(posedge clk) begin
    for (int l = 0; l < 4; l++)
      if (!sram_cs_n[l] && !sram_we_n[l] && sram_dq_oe)
        ram[int'(sram_addr) * 4 + l] = sram_dq_o[l*8 +: 8];
  end

  // reference model: phase counter since acceptance
  int          ph = 0;
  logic        live = 1'b0;
  logic        m_wr;
  logic [1:0]  m_mode;
  logic [31:0] m_wd, m_exp;
  logic [3:0]  m_mask;
  logic [18:0] m_phys;

  always @(posedge clk) begin
    live = !rst;
    if (rst) ph = 0;
    else if (ph == 0) begin
      if (req_valid) begin
        m_wr = req_write; m_mode = req_mode; m_wd = req_wdata;
        case (req_mode)
          2'b01: begin m_phys = req_addr[19:1]; m_mask = req_addr[0] ? 4'b1100 : 4'b0011; end
          2'b10: begin m_phys = req_addr[20:2]; m_mask = 4'b0001 << req_addr[1:0]; end
          default: begin m_phys = req_addr[18:0]; m_mask = 4'b1111; end
        endcase
        m_exp = 32'h0;
        if (m_wr) begin
          for (int l = 0; l < 4; l++)
            if (m_mask[l])
              shadow[int'(m_phys) * 4 + l] = (m_mode == 2'b10) ? m_wd[7:0] :
                                             (m_mode == 2'b01) ? m_wd[(l%2)*8 +: 8] : m_wd[l*8 +: 8];
        end else begin
          case (m_mode)
            2'b01: begin
              m_exp[7:0]  = sh_rd(int'(m_phys) * 4 + (req_addr[0] ? 2 : 0));
              m_exp[15:8] = sh_rd(int'(m_phys) * 4 + (req_addr[0] ? 3 : 1));
            end
            2'b10: m_exp[7:0] = sh_rd(int'(m_phys) * 4 + int'(req_addr[1:0]));
            default: for (int l = 0; l < 4; l++) m_exp[l*8 +: 8] = sh_rd(int'(m_phys) * 4 + l);
          endcase
        end
        ph = 1;
      end
    end else begin
      ph++;
      if (ph > (m_wr ? 1 + WP + REC : RD + 1)) ph = 0;
    end
  end

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'b01: return "R3";
      2'b10: return "R4";
      2'b11: return "R12";
      default: return "R2";
    endcase
  endfunction

  // compared every cycle, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      logic [3:0] e_cs, e_we;
      logic       e_oe, e_dqoe, e_rdy, e_rsp, act;
      string      t;
      e_cs = 4'hF; e_we = 4'hF; e_oe = 1'b1; e_dqoe = 1'b0;
      e_rdy = (ph == 0); e_rsp = 1'b0; act = 1'b0; t = "R1";
      if (ph != 0) begin
        if (!m_wr) begin
          if (ph <= RD) begin e_cs = ~m_mask; e_oe = 1'b0; act = 1'b1; t = "R5"; end
          else begin e_rsp = 1'b1; t = "R9"; end
        end else begin
          t = "R7";
          if (ph == 1) begin e_cs = ~m_mask; act = 1'b1; end
          else if (ph <= 1 + WP) begin e_cs = ~m_mask; e_we = ~m_mask; e_dqoe = 1'b1; act = 1'b1; end
        end
      end
      chk((ph == 0) ? "R1" : "R10", "req_ready", {31'd0, req_ready}, {31'd0, e_rdy});
      chk((m_mode == 2'b01 || m_mode == 2'b10) ? "R11" : t, "cs_n", {28'd0, sram_cs_n}, {28'd0, e_cs});
      chk(t, "we_n", {28'd0, sram_we_n}, {28'd0, e_we});
      chk(t, "oe_n", {31'd0, sram_oe_n}, {31'd0, e_oe});
      chk("R8", "dq_oe", {31'd0, sram_dq_oe}, {31'd0, e_dqoe});
      chk("R6", "rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rsp});
      if (act) chk(mode_tag(m_mode), "sram_addr", {13'd0, sram_addr}, {13'd0, m_phys});
      if (e_rsp) chk(mode_tag(m_mode), "rsp_rdata R6", rsp_rdata, m_exp);
      if (e_dqoe)
        for (int l = 0; l < 4; l++)
          if (m_mask[l])
            chk(mode_tag(m_mode), "dq_o lane R8", {24'd0, sram_dq_o[l*8 +: 8]},
                {24'd0, (m_mode == 2'b10) ? m_wd[7:0] :
                        (m_mode == 2'b01) ? m_wd[(l%2)*8 +: 8] : m_wd[l*8 +: 8]});
    end
  end

  // called at a negedge; valid stays high when calls follow one another
  task automatic issue(input logic wr, input logic [1:0] md, input logic [20:0] a, input logic [31:0] d);
    req_write = wr; req_mode = md; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 21'($urandom);
    req_wdata = $urandom;
    req_write = ~wr;
    req_mode  = 2'($urandom);
  endtask

  function automatic logic [20:0] uaddr(input logic [1:0] md, input int phys, input int sub);
    case (md)
      2'b01: return 21'((phys << 1) | (sub & 1));
      2'b10: return 21'((phys << 2) | (sub & 3));
      default: return 21'(phys);
    endcase
  endfunction

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_mode = 2'b00;
    req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R2 wide write/read
    issue(1'b1, 2'b00, 21'd3, 32'h11223344);
    issue(1'b0, 2'b00, 21'd3, 32'h0);
    // R3 both halves, then wide read of the same word
    issue(1'b1, 2'b01, uaddr(2'b01, 5, 0), 32'hFFFFBEEF);
    issue(1'b1, 2'b01, uaddr(2'b01, 5, 1), 32'h0000CAFE);
    issue(1'b0, 2'b01, uaddr(2'b01, 5, 0), 32'h0);
    issue(1'b0, 2'b01, uaddr(2'b01, 5, 1), 32'h0);
    issue(1'b0, 2'b00, 21'd5, 32'h0);
    // R4 every lane, then wide read
    for (int l = 0; l < 4; l++) issue(1'b1, 2'b10, uaddr(2'b10, 9, l), 32'hABCDEF10 + l);
    for (int l = 0; l < 4; l++) issue(1'b0, 2'b10, uaddr(2'b10, 9, l), 32'h0);
    issue(1'b0, 2'b00, 21'd9, 32'h0);
    // R12 alternate wide code
    issue(1'b1, 2'b11, 21'd7, 32'hDEADBEEF);
    issue(1'b0, 2'b11, 21'd7, 32'h0);
    issue(1'b0, 2'b00, 21'd7, 32'h0);
    // top of the address range, 8-bit lane 3
    issue(1'b1, 2'b10, 21'h1FFFFF, 32'h0000005A);
    issue(1'b0, 2'b00, 21'h07FFFF, 32'h0);
    // R9 read followed at once by a waiting write, back to back
    issue(1'b0, 2'b00, 21'd3, 32'h0);
    issue(1'b1, 2'b00, 21'd3, 32'h55AA55AA);
    issue(1'b0, 2'b00, 21'd3, 32'h0);
    // mixed traffic over a small range
    for (int i = 0; i < 300; i++) begin
      logic [1:0] md;
      md = 2'($urandom);
      issue(1'($urandom), md, uaddr(md, $urandom % 6, $urandom % 4), $urandom);
      if (($urandom % 4) == 0) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule